// File: doc/BRIEF.md
# Prioritised Interrupt-Level Encoder with Board Control Registers

This block gathers thirteen level-sensitive interrupt requests from devices on a board and reduces them to one 4-bit priority code for the processor. Software picks which requests may take part by writing a 16-bit enable word. Each request owns a fixed bit of that word, and the bit order does not follow the priority order. The request that takes part and has the most urgent priority sets the code. The code is inverted before it leaves the block, so a quiet board drives all zeros.

The same 64-byte, 16-bit-wide register window holds three more registers. A general-purpose output latch drives a pin bus. A power-down trigger emits a one-cycle request. A constant identification word cannot be written. Software reaches the window through a plain address, write-enable, write-data and read-data interface. Reads are combinational on the address, and writes commit on the rising clock edge.

Top module: `intr_level_hub`

## Requirements
- R1: Request input `req_i[k]` has priority level k (k = 0..12), and level 0 is the most urgent. Level k is enabled by one bit of the enable word, with this level:bit mapping: 0:11, 1:9, 2:8, 3:12, 4:10, 5:6, 6:5, 7:4, 8:7, 9:14, 10:13, 11:0, 12:15.
- R2: A request takes part only while its input is high and its enable bit is 1. The internal code is the smallest participating level, or 15 when none take part. `level_o` carries that code XOR 15, so level 0 gives 15 and an idle board gives 0.
- R3: `level_o` is registered. It shows the requests and the enable word as they stand at clock edge N, including a write committed at edge N, from just after edge N. Before that edge it keeps its old value.
- R4: The enable word sits at byte offset 0x00. All 16 bits can be written and read back.
- R5: The output latch sits at offset 0x36. A write loads `port_o` with the low PORT_W bits of the write data at the write edge. A read returns the latch zero-extended to 16 bits.
- R6: The power-down register sits at offset 0x30. A write with data bit 0 set makes `off_o` high for exactly the one cycle after the write edge. A write with bit 0 clear gives no pulse. Reads return 0.
- R7: The identification register sits at offset 0x32. It always reads 0x0010, and writes to it change nothing.
- R8: Any other offset, odd offsets included, reads 0. A write there changes neither the enable word nor the output latch, and raises no pulse.
- R9: After a synchronous active-high reset, the enable word and the output latch are 0, and `level_o` and `off_o` are 0.
- R10: Requests are not latched. When an input falls, it stops taking part from the next edge, and the code moves to the next participating level or to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 13 | Level-sensitive interrupt requests, index = priority level |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset in the register window |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| level_o | output | 4 | Inverted priority code |
| port_o | output | PORT_W (16) | Output latch contents |
| off_o | output | 1 | One-cycle power-down request |

## Verification
`rd_data` is due in the same cycle as the address, so the bench drives the address on a falling edge and samples shortly afterwards, with no clock edge between. `level_o`, `port_o` and `off_o` are due one edge after the inputs or the write that caused them. The bench drives those inputs on a falling edge and compares at the next falling edge, when exactly one rising edge has passed. One directed case also samples `level_o` just before that edge, to confirm the output has not yet moved.

// File: rtl/ilh_pkg.sv
package ilh_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 6;
    localparam int NUM_SRC = 13;
    localparam int LVL_W   = 4;
    localparam logic [LVL_W-1:0] LVL_IDLE = 4'hF;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_PWRDN  = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 6'h32;
    localparam logic [ADDR_W-1:0] OFS_LATCH  = 6'h36;
    localparam logic [DATA_W-1:0] IDENT_VAL  = 16'h0010;

    typedef enum logic [2:0] {
        SEL_ENABLE,
        SEL_PWRDN,
        SEL_IDENT,
        SEL_LATCH,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    // Enable-word bit owned by each priority level.
    function automatic logic [3:0] level_bit(input int lvl);
        case (lvl)
            0:       return 4'd11;
            1:       return 4'd9;
            2:       return 4'd8;
            3:       return 4'd12;
            4:       return 4'd10;
            5:       return 4'd6;
            6:       return 4'd5;
            7:       return 4'd4;
            8:       return 4'd7;
            9:       return 4'd14;
            10:      return 4'd13;
            11:      return 4'd0;
            default: return 4'd15;
        endcase
    endfunction

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_ENABLE: return SEL_ENABLE;
            OFS_PWRDN:  return SEL_PWRDN;
            OFS_IDENT:  return SEL_IDENT;
            OFS_LATCH:  return SEL_LATCH;
            default:    return SEL_NONE;
        endcase
    endfunction

    // Smallest participating level; LVL_IDLE when none.
    function automatic logic [LVL_W-1:0] pick_level(input logic [DATA_W-1:0] act);
        logic [LVL_W-1:0] r;
        r = LVL_IDLE;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (act[level_bit(k)]) r = LVL_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/ilh_regs.sv
module ilh_regs
    import ilh_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] enable_nxt,
    output logic [PORT_W-1:0] port_o,
    output logic              off_o
);

    bus_wr_t           wr;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] enable_q;
    logic [PORT_W-1:0] latch_q;
    logic              off_q;

    always_comb begin
        wr.en   = wr_en;
        wr.sel  = decode_ofs(addr);
        wr.data = wdata;
        rd_sel  = decode_ofs(addr);
    end

    // Next enable word, so a write reaches the encoder at its own edge.
    always_comb begin
        enable_nxt = enable_q;
        if (wr.en && wr.sel == SEL_ENABLE) enable_nxt = wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            latch_q  <= '0;
            off_q    <= 1'b0;
        end else begin
            enable_q <= enable_nxt;
            if (wr.en && wr.sel == SEL_LATCH) latch_q <= wr.data[PORT_W-1:0];
            off_q <= wr.en && (wr.sel == SEL_PWRDN) && wr.data[0];
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_ENABLE: rd_data = enable_q;
            SEL_IDENT:  rd_data = IDENT_VAL;
            SEL_LATCH:  rd_data = DATA_W'(latch_q);
            default:    rd_data = '0;
        endcase
    end

    assign port_o = latch_q;
    assign off_o  = off_q;

endmodule

// File: rtl/ilh_encoder.sv
module ilh_encoder
    import ilh_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [DATA_W-1:0]  enable_nxt,
    output logic [LVL_W-1:0]   level_o
);

    logic [DATA_W-1:0] monitor;
    logic [DATA_W-1:0] active;
    logic [LVL_W-1:0]  level_q;

    // Scatter level-indexed requests onto their enable-word bit positions.
    always_comb begin
        monitor = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            monitor[level_bit(k)] = req_i[k];
        end
        active = monitor & enable_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= pick_level(active) ^ LVL_IDLE;
    end

    assign level_o = level_q;

endmodule

// File: rtl/intr_level_hub.sv
module intr_level_hub
    import ilh_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       req_i,
    input  logic              wr_en,
    input  logic [5:0]        addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rd_data,
    output logic [3:0]        level_o,
    output logic [PORT_W-1:0] port_o,
    output logic              off_o
);

    logic [DATA_W-1:0] enable_nxt;

    generate
        if (PORT_W < 1 || PORT_W > DATA_W) begin : g_bad_width
            initial $error("PORT_W must lie in 1..16");
        end
    endgenerate

    ilh_regs #(.PORT_W(PORT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rd_data    (rd_data),
        .enable_nxt (enable_nxt),
        .port_o     (port_o),
        .off_o      (off_o)
    );

    ilh_encoder u_enc (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .enable_nxt (enable_nxt),
        .level_o    (level_o)
    );

endmodule

// File: rtl/intr_level_hub_chk.sv
module intr_level_hub_chk #(
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [12:0]       req_i,
    input logic              wr_en,
    input logic [5:0]        addr,
    input logic [15:0]       wdata,
    input logic [15:0]       rd_data,
    input logic [3:0]        level_o,
    input logic [PORT_W-1:0] port_o,
    input logic              off_o
);

    // Top code only when the level-0 request was present at the edge.
    assert_top_level_R2: assert property (@(posedge clk) disable iff (rst)
        (level_o == 4'hF) |-> $past(req_i[0]));

    // No request at the edge means idle output.
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(req_i) == 13'd0) |-> (level_o == 4'h0));

    assert_pulse_src_R6: assert property (@(posedge clk) disable iff (rst)
        off_o |-> $past(wr_en && addr == 6'h30 && wdata[0]));

    assert_pulse_gen_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 6'h30 && wdata[0]) |=> off_o);

    assert_pwrdn_read_R6: assert property (@(posedge clk) disable iff (rst)
        (addr == 6'h30) |-> (rd_data == 16'h0000));

    assert_ident_R7: assert property (@(posedge clk) disable iff (rst)
        (addr == 6'h32) |-> (rd_data == 16'h0010));

    assert_latch_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 6'h36) |=> (port_o == $past(wdata[PORT_W-1:0])));

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && addr == 6'h36)) |=> $stable(port_o));

endmodule

bind intr_level_hub intr_level_hub_chk #(.PORT_W(PORT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_data (rd_data),
    .level_o (level_o),
    .port_o  (port_o),
    .off_o   (off_o)
);

// File: tb/intr_level_hub_tb_top.sv
`timescale 1ns/1ps
module intr_level_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] req = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic [3:0]  level_o;
    logic [15:0] port_o;
    logic        off_o;

    int vecs = 0;
    int miss = 0;
    logic [15:0] en_m   = '0;
    logic [15:0] port_m = '0;

    always #10 clk = ~clk;

    intr_level_hub dut_i (
        .clk(clk), .rst(rst), .req_i(req), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .level_o(level_o),
        .port_o(port_o), .off_o(off_o)
    );

    function automatic int bit_of(input int lvl);
        int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return t[lvl];
    endfunction

    function automatic logic [3:0] exp_level(input logic [12:0] r, input logic [15:0] en);
        for (int k = 0; k < 13; k++)
            if (r[k] && en[bit_of(k)]) return 4'(k) ^ 4'hF;
        return 4'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [12:0] r, input logic we, input logic [5:0] a,
                        input logic [15:0] d, input string tag);
        logic xo;
        @(negedge clk);
        req = r; wr_en = we; addr = a; wdata = d;
        if (we && a == 6'h00) en_m = d;
        if (we && a == 6'h36) port_m = d;
        xo = we && a == 6'h30 && d[0];
        @(negedge clk);
        wr_en = 1'b0;
        chk(level_o == exp_level(r, en_m), {tag, " level"}, 16'(level_o), 16'(exp_level(r, en_m)));
        chk(off_o == xo, {tag, " off R6"}, 16'(off_o), 16'(xo));
        chk(port_o == port_m, {tag, " port R5"}, port_o, port_m);
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #2;
        chk(rd_data == e, tag, rd_data, e);
    endtask

    initial begin
        #(20 * 200000);
        miss++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        #2;
        chk(level_o == 4'h0, "R9 level", 16'(level_o), 16'h0);
        chk(off_o == 1'b0, "R9 off", 16'(off_o), 16'h0);
        chk(port_o == 16'h0, "R9 port", port_o, 16'h0);
        rd_chk(6'h00, 16'h0000, "R9 enable read");

        // R4 enable readback
        step('0, 1'b1, 6'h00, 16'hA5C3, "R4 write");
        rd_chk(6'h00, 16'hA5C3, "R4 read");
        step('0, 1'b1, 6'h00, 16'hFFFF, "R4 all-on");

        // R1 each level alone
        for (int k = 0; k < 13; k++)
            step(13'(1 << k), 1'b0, 6'h00, 16'h0, $sformatf("R1 level %0d", k));

        // R2 masked source ignored, lower level wins
        step(13'h1FFF, 1'b0, 6'h00, 16'h0, "R2 all high");
        step(13'h1FFF, 1'b1, 6'h00, 16'hF7FF, "R2 level0 masked");
        step(13'h0006, 1'b1, 6'h00, 16'h0100, "R2 only level2 on");

        // R3 same-edge write and no early change
        step('0, 1'b1, 6'h00, 16'hFFFF, "R3 prep");
        @(negedge clk); req = 13'h0010;
        #2 chk(level_o == 4'h0, "R3 before edge", 16'(level_o), 16'h0);
        @(posedge clk); #2;
        chk(level_o == 4'hB, "R3 after edge", 16'(level_o), 16'hB);

        // R10 drop request
        step(13'h0030, 1'b0, 6'h00, 16'h0, "R10 two up");
        step(13'h0020, 1'b0, 6'h00, 16'h0, "R10 level4 drops");
        step(13'h0000, 1'b0, 6'h00, 16'h0, "R10 all drop");

        // R5 output latch
        step('0, 1'b1, 6'h36, 16'h3C5A, "R5 write");
        rd_chk(6'h36, 16'h3C5A, "R5 read");

        // R6 power-down
        step('0, 1'b1, 6'h30, 16'h0001, "R6 pulse");
        step('0, 1'b1, 6'h30, 16'hFFFE, "R6 bit0 clear");
        rd_chk(6'h30, 16'h0000, "R6 read");

        // R7 identification
        step('0, 1'b1, 6'h32, 16'hBEEF, "R7 write");
        rd_chk(6'h32, 16'h0010, "R7 read");

        // R8 unmapped and odd offsets
        step('0, 1'b1, 6'h01, 16'h1234, "R8 odd 0x01");
        step('0, 1'b1, 6'h37, 16'h5678, "R8 odd 0x37");
        step('0, 1'b1, 6'h3E, 16'h0001, "R8 0x3E");
        rd_chk(6'h00, en_m, "R8 enable kept");
        rd_chk(6'h36, port_m, "R8 latch kept");
        rd_chk(6'h02, 16'h0000, "R8 read 0x02");
        rd_chk(6'h31, 16'h0000, "R8 read 0x31");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [5:0] a;
            int pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0: a = 6'h00;
                1: a = 6'h30;
                2: a = 6'h32;
                3: a = 6'h36;
                default: a = 6'($urandom);
            endcase
            step(13'($urandom), 1'($urandom), a, 16'($urandom), "R2 random");
            if (i % 8 == 0) rd_chk(6'h00, en_m, "R4 random read");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

endmodule